// File: doc/BRIEF.md
# PDM Microphone Clock and Capture Front End

This block derives the clock for one or two PDM microphones from the system clock and samples their shared data line. A programmable even divider sets the microphone clock period. A bypass mode forwards the system clock itself to the pin. A separate control bit drives the enable of the clock pin. Within each half of the microphone clock, the data line is sampled a programmable number of system cycles after the half begins. Two microphones that share the line and drive it on opposite clock levels can therefore be captured separately.

Each channel has a polarity bit that picks the clock level in which it is captured. A mode bit chooses one channel (channel 0 only) or two channels. In the usual two-channel setup, channel 1 is the microphone that drives during the high level and channel 0 is the one that drives during the low level. Every captured bit comes with a one-cycle valid strobe. A downstream decimation filter consumes these bits.

Top module: `pdm_capture_front`

## Requirements
- R1: After `enable` rises with `bypass` low, `pdm_clk` is high from the next cycle on. Each period is a high half followed by a low half, both `max(div_code,1)+1` system cycles long, so the period is `2*(max(div_code,1)+1)` cycles.
- R2: A `div_code` of 0 is handled as code 1, so the clock period is never shorter than 4 system cycles.
- R3: A new `div_code` written while the clock runs takes effect only at the start of the next high half. The current period ends with its old half length.
- R4: While `enable` and `bypass` are both high, `pdm_clk` follows the system clock starting one cycle later. Channel 0 then delivers a strobe every cycle, carrying `pdm_din` as sampled at the previous edge. Channel 1 delivers no strobe, and `capt_delay` has no effect.
- R5: `pdm_clk_oe` equals `clk_oe_cfg` delayed by one cycle, whatever the value of `enable`.
- R6: A channel samples `pdm_din` once per period, at the edge that ends the system cycle whose in-half count equals `capt_delay`. The count runs from 0 at the start of the half. The channel's `smp_vld` bit is high for exactly one cycle, `capt_delay+1` cycles after its half begins.
- R7: Bit c of `chan_pol` selects the level in which channel c is captured: 1 selects the high level and 0 selects the low level. The `smp_bit` value delivered is `pdm_din` as sampled.
- R8: With `two_chan` low, only channel 0 (bit 0 of `smp_bit`/`smp_vld`) produces strobes. With `two_chan` high, both channels do.
- R9: While `enable` is low, `pdm_clk` is held low and no strobe is produced on either channel.
- R10: If `capt_delay` is larger than `max(div_code,1)`, no sampling point falls inside a half and no strobes are produced.
- R11: While `rst` is high, `pdm_clk`, `pdm_clk_oe` and both `smp_vld` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the clock generator and capture |
| div_code | input | DIV_W | Divider code n; period 2*(n+1) cycles, minimum n=1 |
| bypass | input | 1 | Forward the system clock to the pin instead of the divided clock |
| clk_oe_cfg | input | 1 | Requested enable for the clock pin driver |
| capt_delay | input | DLY_W | Sampling offset in system cycles within each clock half |
| chan_pol | input | NCH | Per-channel capture level: 1 = high half, 0 = low half |
| two_chan | input | 1 | 1 = capture both channels, 0 = channel 0 only |
| pdm_din | input | 1 | Shared PDM data line |
| pdm_clk | output | 1 | Microphone clock |
| pdm_clk_oe | output | 1 | Output enable of the clock pin |
| smp_bit | output | NCH | Captured bit per channel |
| smp_vld | output | NCH | One-cycle strobe per channel marking a new bit |

## Verification
A wrong phase counter shows at the ports within one microphone clock period. The symptom is a high or low half of the wrong length, or a strobe that lands a cycle early or late against the edge of `pdm_clk`. The bench compares every cycle of several periods with a timeline computed from the code, delay and polarity. A channel or level mix-up shows at the next strobe as a bit with the wrong value, or as a strobe on the wrong channel. Divider-code latching faults show only in the period after a code change, so that case is checked over several periods following the change.

// File: rtl/pdmcap_pkg.sv
package pdmcap_pkg;

  // Level of the microphone clock during a half period.
  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } pdm_level_e;

  function automatic int max_w(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pdmcap_divider.sv
// Even clock divider: each half lasts cur_q+1 system cycles.
// The code is sampled only when a new period (high half) begins.
module pdmcap_divider #(
  parameter int DIV_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run,
  input  logic [DIV_W-1:0]       div_code,
  output pdmcap_pkg::pdm_level_e level,
  output logic [DIV_W-1:0]       cnt,
  output logic                   active
);
  import pdmcap_pkg::*;

  localparam logic [DIV_W-1:0] MIN_CODE = DIV_W'(1);

  logic [DIV_W-1:0] code_eff;
  logic [DIV_W-1:0] cur_q;
  logic [DIV_W-1:0] cnt_q;
  pdm_level_e       lvl_q;
  logic             act_q;
  logic             half_end;

  // Never divide by less than four.
  assign code_eff = (div_code == '0) ? MIN_CODE : div_code;
  assign half_end = (cnt_q == cur_q);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      act_q <= 1'b0;
      lvl_q <= LVL_LOW;
      cnt_q <= '0;
      cur_q <= MIN_CODE;
    end else if (!act_q) begin
      act_q <= 1'b1;
      lvl_q <= LVL_HIGH;
      cnt_q <= '0;
      cur_q <= code_eff;
    end else if (half_end) begin
      cnt_q <= '0;
      if (lvl_q == LVL_LOW) begin
        lvl_q <= LVL_HIGH;
        cur_q <= code_eff;
      end else begin
        lvl_q <= LVL_LOW;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level  = lvl_q;
  assign cnt    = cnt_q;
  assign active = act_q;

endmodule

// File: rtl/pdmcap_chan_sampler.sv
// One capture channel: takes the data line at its programmed point.
module pdmcap_chan_sampler #(
  parameter int CNT_W = 4,
  parameter int DLY_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   arm,
  input  logic                   force_take,
  input  pdmcap_pkg::pdm_level_e want,
  input  pdmcap_pkg::pdm_level_e level,
  input  logic [CNT_W-1:0]       cnt,
  input  logic [DLY_W-1:0]       delay,
  input  logic                   din,
  output logic                   bit_o,
  output logic                   vld_o
);
  localparam int CMP_W = pdmcap_pkg::max_w(CNT_W, DLY_W);

  logic [CMP_W-1:0] cnt_x;
  logic [CMP_W-1:0] dly_x;
  logic             take;
  logic             bit_q;
  logic             vld_q;

  assign cnt_x = CMP_W'(cnt);
  assign dly_x = CMP_W'(delay);
  assign take  = force_take | (arm && (level == want) && (cnt_x == dly_x));

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= take;
      if (take) bit_q <= din;
    end
  end

  assign bit_o = bit_q;
  assign vld_o = vld_q;

endmodule

// File: rtl/pdm_capture_front.sv
module pdm_capture_front #(
  parameter int DIV_W = 4,
  parameter int DLY_W = 4,
  parameter int NCH   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_code,
  input  logic             bypass,
  input  logic             clk_oe_cfg,
  input  logic [DLY_W-1:0] capt_delay,
  input  logic [NCH-1:0]   chan_pol,
  input  logic             two_chan,
  input  logic             pdm_din,
  output logic             pdm_clk,
  output logic             pdm_clk_oe,
  output logic [NCH-1:0]   smp_bit,
  output logic [NCH-1:0]   smp_vld
);
  import pdmcap_pkg::*;

  logic             div_run;
  logic             div_act;
  pdm_level_e       div_level;
  logic [DIV_W-1:0] div_cnt;
  logic             byp_run;
  logic             byp_q;
  logic             oe_q;

  assign div_run = enable & ~bypass;
  assign byp_run = enable & bypass;

  pdmcap_divider #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (div_run),
    .div_code (div_code),
    .level    (div_level),
    .cnt      (div_cnt),
    .active   (div_act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      byp_q <= byp_run;
      oe_q  <= clk_oe_cfg;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic ch_arm;
    logic ch_force;

    if (c == 0) begin : g_first
      assign ch_arm   = div_act & div_run;
      assign ch_force = byp_run;
    end else begin : g_other
      assign ch_arm   = div_act & div_run & two_chan;
      assign ch_force = 1'b0;
    end

    pdmcap_chan_sampler #(.CNT_W(DIV_W), .DLY_W(DLY_W)) u_smp (
      .clk        (clk),
      .rst        (rst),
      .arm        (ch_arm),
      .force_take (ch_force),
      .want       (pdm_level_e'(chan_pol[c])),
      .level      (div_level),
      .cnt        (div_cnt),
      .delay      (capt_delay),
      .din        (pdm_din),
      .bit_o      (smp_bit[c]),
      .vld_o      (smp_vld[c])
    );
  end

  // In bypass the system clock itself drives the pin.
  assign pdm_clk    = byp_q ? clk : div_level;
  assign pdm_clk_oe = oe_q;

endmodule

// File: rtl/pdmcap_checker.sv
module pdmcap_checker #(
  parameter int DLY_W = 4,
  parameter int NCH   = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             bypass,
  input logic             clk_oe_cfg,
  input logic [DLY_W-1:0] capt_delay,
  input logic [NCH-1:0]   chan_pol,
  input logic             two_chan,
  input logic             pdm_din,
  input logic             pdm_clk,
  input logic             pdm_clk_oe,
  input logic             smp_bit0,
  input logic [NCH-1:0]   smp_vld
);

  assert_clk_starts_high_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(enable) && enable && !bypass) |=> pdm_clk);

  assert_bypass_stream_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(enable && bypass)) |->
      (smp_vld == NCH'(1) && smp_bit0 == $past(pdm_din)));

  assert_oe_follows_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pdm_clk_oe == $past(clk_oe_cfg)));

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (smp_vld[NCH-1] && !bypass) |=>
      (!smp_vld[NCH-1] || !$stable(capt_delay) || !$stable(chan_pol)));

  assert_one_channel_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(two_chan)) |-> !smp_vld[NCH-1]);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(enable)) |-> (!pdm_clk && smp_vld == '0));

endmodule

bind pdm_capture_front pdmcap_checker #(.DLY_W(DLY_W), .NCH(NCH)) u_pdmcap_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .bypass     (bypass),
  .clk_oe_cfg (clk_oe_cfg),
  .capt_delay (capt_delay),
  .chan_pol   (chan_pol),
  .two_chan   (two_chan),
  .pdm_din    (pdm_din),
  .pdm_clk    (pdm_clk),
  .pdm_clk_oe (pdm_clk_oe),
  .smp_bit0   (smp_bit[0]),
  .smp_vld    (smp_vld)
);

// File: tb/pdm_capture_front_bench.sv
module pdm_capture_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {div_code[10:7], capt_delay[6:3], chan_pol[2:1], two_chan[0]}
  localparam logic [10:0] VEC [NVEC] = '{
    {4'd1, 4'd0, 2'b10, 1'b1},
    {4'd0, 4'd1, 2'b10, 1'b1},
    {4'd3, 4'd2, 2'b01, 1'b1},
    {4'd2, 4'd2, 2'b11, 1'b0},
    {4'd5, 4'd6, 2'b10, 1'b1},
    {4'd4, 4'd0, 2'b00, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [3:0] div_code = 4'd1;
  logic bypass = 1'b0;
  logic clk_oe_cfg = 1'b0;
  logic [3:0] capt_delay = 4'd0;
  logic [1:0] chan_pol = 2'b10;
  logic two_chan = 1'b1;
  logic pdm_din = 1'b0;
  logic pdm_clk, pdm_clk_oe;
  logic [1:0] smp_bit, smp_vld;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdm_capture_front u_pdm_capture_front (
    .clk(clk), .rst(rst), .enable(enable), .div_code(div_code), .bypass(bypass),
    .clk_oe_cfg(clk_oe_cfg), .capt_delay(capt_delay), .chan_pol(chan_pol),
    .two_chan(two_chan), .pdm_din(pdm_din), .pdm_clk(pdm_clk),
    .pdm_clk_oe(pdm_clk_oe), .smp_bit(smp_bit), .smp_vld(smp_vld)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    // R11: reset dominates enable and oe request
    enable = 1'b1; clk_oe_cfg = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 clk", int'(pdm_clk), 0);
    check("R11 oe", int'(pdm_clk_oe), 0);
    check("R11 vld", int'(smp_vld), 0);
    enable = 1'b0; clk_oe_cfg = 1'b0;
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);

    // R5: oe follows request one cycle later, enable low
    clk_oe_cfg = 1'b1;
    @(negedge clk); check("R5 oe set", int'(pdm_clk_oe), 1);
    clk_oe_cfg = 1'b0;
    @(negedge clk); check("R5 oe clear", int'(pdm_clk_oe), 0);

    // Table walk: R1 R2 R6 R7 R8 R10
    for (int v = 0; v < NVEC; v++) begin
      int h, per, clk_bad, vld_bad, bit_bad;
      enable = 1'b0;
      repeat (2) @(negedge clk);
      {div_code, capt_delay, chan_pol, two_chan} = VEC[v];
      h = ((div_code == 0) ? 1 : int'(div_code)) + 1;
      per = 2 * h;
      clk_bad = 0; vld_bad = 0; bit_bad = 0;
      pdm_din = 1'b0;
      enable = 1'b1;
      for (int t = 0; t < 4 * per; t++) begin
        @(negedge clk);
        if (pdm_clk !== ((t % per) < h)) clk_bad++;
        for (int c = 0; c < 2; c++) begin
          logic ev;
          int off;
          off = chan_pol[c] ? 0 : h;
          ev = ((c == 0) || two_chan) && (int'(capt_delay) < h) && (t >= 1)
               && (((t - 1) % per) == int'(capt_delay) + off);
          if (smp_vld[c] !== ev) vld_bad++;
          if (ev && smp_bit[c] !== chan_pol[c]) bit_bad++;
        end
        pdm_din = pdm_clk;
      end
      check(v == 1 ? "R2 period clamp" : "R1 clock shape", clk_bad, 0);
      check(v == 4 ? "R10 no strobe" : (v == 3 ? "R8 strobe timing" : "R6 strobe timing"), vld_bad, 0);
      check("R7 captured bit", bit_bad, 0);
    end

    // R9: disabling stops clock and strobes
    enable = 1'b0;
    begin
      int bad = 0;
      for (int t = 0; t < 10; t++) begin
        @(negedge clk);
        if (pdm_clk !== 1'b0 || smp_vld !== 2'b00) bad++;
        pdm_din = ~pdm_din;
      end
      check("R9 idle", bad, 0);
    end

    // R3: code change mid-period
    div_code = 4'd1; capt_delay = 4'd0; chan_pol = 2'b10; two_chan = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    begin
      int bad = 0;
      for (int t = 0; t < 20; t++) begin
        logic ex;
        @(negedge clk);
        ex = (t < 4) ? ((t % 4) < 2) : (((t - 4) % 8) < 4);
        if (pdm_clk !== ex) bad++;
        if (t == 1) div_code = 4'd3;
      end
      check("R3 code change", bad, 0);
    end

    // R4: bypass
    enable = 1'b0;
    repeat (2) @(negedge clk);
    bypass = 1'b1; capt_delay = 4'd3; enable = 1'b1;
    begin
      int bad = 0;
      logic prev;
      prev = pdm_din;
      for (int t = 0; t < 10; t++) begin
        @(negedge clk);
        if (smp_vld !== 2'b01 || smp_bit[0] !== prev) bad++;
        pdm_din = (t % 3) == 1;
        prev = pdm_din;
      end
      check("R4 bypass stream", bad, 0);
    end
    @(posedge clk); #1;
    check("R4 clk high", int'(pdm_clk), 1);
    @(negedge clk); #1;
    check("R4 clk low", int'(pdm_clk), 0);
    enable = 1'b0; bypass = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 after bypass", int'(pdm_clk), 0);

    finish_run();
  end

endmodule